// File: doc/BRIEF.md
# Integer ALU with Flag Generation

This block is a 32-bit integer arithmetic and logic unit for a processor datapath. Each cycle it takes an operation code and two operands and forms the result combinationally. It covers addition, subtraction, signed minimum and maximum, bitwise logic, left and right shifts, arithmetic right shift, rotate and a leading-zero count.

Three status flags sit beside the result: zero (Z), negative (N) and carry (C). They are written at the next rising clock edge, and only when the set-flags input is high. Z and N mean the same thing for every operation. The meaning of C depends on the operation: it is an unsigned carry out, an unsigned borrow, a signed comparison outcome, or the last bit shifted out. This lets a following conditional instruction test the carry flag for the relation it needs.

A control module decodes the operation code into a small strobe bundle. A datapath module holds the arithmetic, the result multiplexer and the flag registers.

Top module: `int_alu_flags`

## Requirements
- R1: Operation code 0 (add) outputs opA + opB modulo 2^32. The carry it produces is 1 exactly when the unsigned sum exceeds 0xFFFFFFFF.
- R2: Operation code 1 (subtract) outputs opA - opB modulo 2^32. The carry it produces is 1 exactly when opA < opB, both taken as unsigned.
- R3: Operation codes 2 (minimum) and 3 (maximum) compare the operands as signed 32-bit integers and output the smaller or the larger one. The carry is 1 exactly when opA > opB (signed).
- R4: Operation codes 4 (and), 5 (or) and 6 (xor) output the bitwise function of the operands. Operation code 11 (invert) outputs ~opA and does not depend on opB. All four produce carry 0.
- R5: Operation code 7 (shift left) shifts opA left by s = opB[4:0]. The carry is bit (32 - s) of opA, the last bit shifted out, and is 0 when s = 0.
- R6: Operation code 8 (logical right shift) fills with zeros and operation code 9 (arithmetic right shift) fills with opA[31]. Both shift by s = opB[4:0], and the carry is bit (s - 1) of opA, which is 0 when s = 0.
- R7: Operation code 10 (rotate right) rotates opA right by opB[4:0] and produces carry 0.
- R8: Operation code 12 (leading-zero count) outputs the number of zero bits above the highest set bit of opA, or 32 when opA is 0. The carry and N are both 0.
- R9: When setFlags is high at a rising clock edge, Z is written with (result == 0), N with result[31] and C with the carry of the current operation. The flags change only at that edge.
- R10: When setFlags is low at a rising clock edge, Z, N and C keep their values.
- R11: An active-low reset (rstN) clears Z, N and C at once.
- R12: Operation codes 13 to 15 are unused. They output 0 and produce carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 4 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (shift or rotate amount for shifts) |
| setFlags | input | 1 | Write the flags at the next rising edge |
| result | output | 32 | Combinational result |
| flagZ | output | 1 | Registered zero flag |
| flagN | output | 1 | Registered negative flag |
| flagC | output | 1 | Registered carry flag |

## Verification
The assertions check on every cycle the rules that hold across all operations:
- Flags keep their values while set-flags is low.
- Z and N follow the previous result when set-flags is high.
- The add and subtract carries match an unsigned compare of the previous operands.
- Logic, rotate and leading-zero operations leave C clear.
- The leading-zero count stays within 0 to 32.

The exact result values, and the operation-specific carry for shifts and signed compares, can only be shown by the bench's scenarios. These include a shift amount of zero, amounts wider than five bits, the 0x80000000 boundary, an all-zero count input and the unused codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MIN = 4'd2,
    OP_MAX = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_ASR = 4'd9,
    OP_ROR = 4'd10,
    OP_NOT = 4'd11,
    OP_CLZ = 4'd12
  } aluOp_e;

  typedef enum logic [2:0] {
    RS_ADDSUB,
    RS_MINMAX,
    RS_LOGIC,
    RS_SHIFT,
    RS_CLZ,
    RS_ZERO
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_INV
  } logicOp_e;

  typedef enum logic [1:0] {
    SK_SHL,
    SK_SHR,
    SK_ASR,
    SK_ROR
  } shiftKind_e;

  typedef enum logic [2:0] {
    CS_ZERO,
    CS_CARRY,
    CS_BORROW,
    CS_SGT,
    CS_SHIFT
  } carrySrc_e;

  typedef struct packed {
    resSel_e    resSel;
    logic       subtract;
    logic       pickMax;
    logicOp_e   logicOp;
    shiftKind_e shiftKind;
    carrySrc_e  carrySrc;
    logic       flagWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]   opSel,
  input  logic         setFlags,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes           = '0;
    strobes.resSel    = RS_ZERO;
    strobes.logicOp   = LG_AND;
    strobes.shiftKind = SK_SHL;
    strobes.carrySrc  = CS_ZERO;
    strobes.flagWr    = setFlags;
    case (opSel)
      4'(OP_ADD): begin
        strobes.resSel   = RS_ADDSUB;
        strobes.carrySrc = CS_CARRY;
      end
      4'(OP_SUB): begin
        strobes.resSel   = RS_ADDSUB;
        strobes.subtract = 1'b1;
        strobes.carrySrc = CS_BORROW;
      end
      4'(OP_MIN): begin
        strobes.resSel   = RS_MINMAX;
        strobes.carrySrc = CS_SGT;
      end
      4'(OP_MAX): begin
        strobes.resSel   = RS_MINMAX;
        strobes.pickMax  = 1'b1;
        strobes.carrySrc = CS_SGT;
      end
      4'(OP_AND): strobes.resSel = RS_LOGIC;
      4'(OP_OR): begin
        strobes.resSel  = RS_LOGIC;
        strobes.logicOp = LG_OR;
      end
      4'(OP_XOR): begin
        strobes.resSel  = RS_LOGIC;
        strobes.logicOp = LG_XOR;
      end
      4'(OP_NOT): begin
        strobes.resSel  = RS_LOGIC;
        strobes.logicOp = LG_INV;
      end
      4'(OP_SHL): begin
        strobes.resSel   = RS_SHIFT;
        strobes.carrySrc = CS_SHIFT;
      end
      4'(OP_SHR): begin
        strobes.resSel    = RS_SHIFT;
        strobes.shiftKind = SK_SHR;
        strobes.carrySrc  = CS_SHIFT;
      end
      4'(OP_ASR): begin
        strobes.resSel    = RS_SHIFT;
        strobes.shiftKind = SK_ASR;
        strobes.carrySrc  = CS_SHIFT;
      end
      4'(OP_ROR): begin
        strobes.resSel    = RS_SHIFT;
        strobes.shiftKind = SK_ROR;
      end
      4'(OP_CLZ): strobes.resSel = RS_CLZ;
      default: ;
    endcase
  end

  // Carry source and result selector must agree for the signed compare path
  always_comb begin
    AST_SGT_ONLY_MINMAX: assert ((strobes.carrySrc != CS_SGT) || (strobes.resSel == RS_MINMAX)); // R3
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagC
);

  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0]          shAmt;
  logic [WIDTH-1:0]        opBx;
  logic [WIDTH:0]          sumFull;
  logic                    aGtB;
  logic [WIDTH-1:0]        minMaxRes;
  logic [WIDTH-1:0]        logicRes;
  logic [WIDTH:0]          shlWide;
  logic [WIDTH:0]          shrWide;
  logic signed [WIDTH:0]   asrWide;
  logic [2*WIDTH-1:0]      rorWide;
  logic [WIDTH-1:0]        shiftRes;
  logic                    shiftOut;
  logic [SHW:0]            clzCnt;
  logic                    carryNext;

  function automatic logic [SHW:0] countLeadZeros(input logic [WIDTH-1:0] v);
    logic found;
    countLeadZeros = '0;
    found = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else countLeadZeros = countLeadZeros + 1'b1;
      end
    end
  endfunction

  assign shAmt   = opB[SHW-1:0];
  assign opBx    = strobes.subtract ? ~opB : opB;
  assign sumFull = {1'b0, opA} + {1'b0, opBx} + {{WIDTH{1'b0}}, strobes.subtract};
  assign aGtB    = $signed(opA) > $signed(opB);
  assign minMaxRes = (aGtB == strobes.pickMax) ? opA : opB;

  always_comb begin
    case (strobes.logicOp)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
  end

  assign shlWide = {1'b0, opA} << shAmt;
  assign shrWide = {opA, 1'b0} >> shAmt;
  assign asrWide = $signed({opA, 1'b0}) >>> shAmt;
  assign rorWide = {opA, opA} >> shAmt;

  always_comb begin
    case (strobes.shiftKind)
      SK_SHL: begin
        shiftRes = shlWide[WIDTH-1:0];
        shiftOut = shlWide[WIDTH];
      end
      SK_SHR: begin
        shiftRes = shrWide[WIDTH:1];
        shiftOut = shrWide[0];
      end
      SK_ASR: begin
        shiftRes = asrWide[WIDTH:1];
        shiftOut = asrWide[0];
      end
      default: begin
        shiftRes = rorWide[WIDTH-1:0];
        shiftOut = 1'b0;
      end
    endcase
  end

  assign clzCnt = countLeadZeros(opA);

  always_comb begin
    case (strobes.resSel)
      RS_ADDSUB: result = sumFull[WIDTH-1:0];
      RS_MINMAX: result = minMaxRes;
      RS_LOGIC:  result = logicRes;
      RS_SHIFT:  result = shiftRes;
      RS_CLZ:    result = {{(WIDTH-SHW-1){1'b0}}, clzCnt};
      default:   result = '0;
    endcase
  end

  always_comb begin
    case (strobes.carrySrc)
      CS_CARRY:  carryNext = sumFull[WIDTH];
      CS_BORROW: carryNext = ~sumFull[WIDTH];
      CS_SGT:    carryNext = aGtB;
      CS_SHIFT:  carryNext = shiftOut;
      default:   carryNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagZ <= 1'b0;
      flagN <= 1'b0;
      flagC <= 1'b0;
    end else if (strobes.flagWr) begin
      flagZ <= (result == '0);
      flagN <= result[WIDTH-1];
      flagC <= carryNext;
    end
  end

  AST_CLZ_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.resSel == RS_CLZ) |-> (result <= WIDTH)); // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.resSel == RS_ZERO && strobes.flagWr) |=> (flagZ && !flagC)); // R12

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             setFlags,
  output logic [WIDTH-1:0] result,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagC
);

  ctrlStrobes_t strobes;

  alu_ctrl uCtrl (
    .opSel    (opSel),
    .setFlags (setFlags),
    .strobes  (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .flagZ   (flagZ),
    .flagN   (flagN),
    .flagC   (flagC)
  );

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !setFlags |=> $stable({flagZ, flagN, flagC})); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    setFlags |=> (flagZ == ($past(result) == '0))); // R9

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    setFlags |=> (flagN == $past(result[WIDTH-1]))); // R9

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel == 4'(OP_ADD)) |=>
      (flagC == (({1'b0, $past(opA)} + {1'b0, $past(opB)}) > {1'b0, {WIDTH{1'b1}}}))); // R1

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel == 4'(OP_SUB)) |=> (flagC == ($past(opA) < $past(opB)))); // R2

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && (opSel == 4'(OP_AND) || opSel == 4'(OP_OR) ||
                  opSel == 4'(OP_XOR) || opSel == 4'(OP_NOT))) |=> !flagC); // R4

  AST_ROR_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel == 4'(OP_ROR)) |=> !flagC); // R7

  AST_CLZ_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel == 4'(OP_CLZ)) |=> (!flagN && !flagC)); // R8

endmodule

// File: tb/int_alu_flags_test.sv
module int_alu_flags_test;

  localparam int NV = 34;

  logic        clk;
  logic        rstN;
  logic [3:0]  opSel;
  logic [31:0] opA;
  logic [31:0] opB;
  logic        setFlags;
  logic [31:0] result;
  logic        flagZ;
  logic        flagN;
  logic        flagC;

  int checks;
  int failures;
  bit finished;

  int_alu_flags uut (
    .clk      (clk),
    .rstN     (rstN),
    .opSel    (opSel),
    .opA      (opA),
    .opB      (opB),
    .setFlags (setFlags),
    .result   (result),
    .flagZ    (flagZ),
    .flagN    (flagN),
    .flagC    (flagC)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {op, A, B, expected result, Z, N, C}
  localparam logic [102:0] VEC [NV] = '{
    {4'd0,  32'h00000001, 32'h00000002, 32'h00000003, 3'b000},
    {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 3'b101},
    {4'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b010},
    {4'd0,  32'h80000000, 32'h80000000, 32'h00000000, 3'b101},
    {4'd1,  32'h00000005, 32'h00000003, 32'h00000002, 3'b000},
    {4'd1,  32'h00000003, 32'h00000005, 32'hFFFFFFFE, 3'b011},
    {4'd1,  32'h00000007, 32'h00000007, 32'h00000000, 3'b100},
    {4'd2,  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 3'b010},
    {4'd2,  32'h00000005, 32'h00000003, 32'h00000003, 3'b001},
    {4'd3,  32'hFFFFFFFF, 32'h00000001, 32'h00000001, 3'b000},
    {4'd3,  32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 3'b000},
    {4'd3,  32'h00000005, 32'h00000005, 32'h00000005, 3'b000},
    {4'd4,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 3'b010},
    {4'd5,  32'h00000000, 32'h00000000, 32'h00000000, 3'b100},
    {4'd6,  32'hAAAAAAAA, 32'hFFFFFFFF, 32'h55555555, 3'b000},
    {4'd11, 32'h00000000, 32'h12345678, 32'hFFFFFFFF, 3'b010},
    {4'd7,  32'h80000001, 32'h00000001, 32'h00000002, 3'b001},
    {4'd7,  32'h00000001, 32'h00000000, 32'h00000001, 3'b000},
    {4'd7,  32'hFFFFFFFF, 32'h00000021, 32'hFFFFFFFE, 3'b011},
    {4'd7,  32'h00000002, 32'h0000001F, 32'h00000000, 3'b101},
    {4'd8,  32'h00000003, 32'h00000001, 32'h00000001, 3'b001},
    {4'd8,  32'h80000000, 32'h0000001F, 32'h00000001, 3'b000},
    {4'd8,  32'h80000000, 32'h00000000, 32'h80000000, 3'b010},
    {4'd9,  32'h80000000, 32'h00000004, 32'hF8000000, 3'b010},
    {4'd9,  32'h8000000C, 32'h00000003, 32'hF0000001, 3'b011},
    {4'd10, 32'h00000001, 32'h00000001, 32'h80000000, 3'b010},
    {4'd10, 32'h12345678, 32'h00000020, 32'h12345678, 3'b000},
    {4'd10, 32'h12345678, 32'h00000004, 32'h81234567, 3'b010},
    {4'd12, 32'h00000000, 32'h00000000, 32'h00000020, 3'b000},
    {4'd12, 32'h00000001, 32'h00000000, 32'h0000001F, 3'b000},
    {4'd12, 32'h80000000, 32'h00000000, 32'h00000000, 3'b100},
    {4'd12, 32'h00010000, 32'h00000000, 32'h0000000F, 3'b000},
    {4'd13, 32'h00000005, 32'h00000005, 32'h00000000, 3'b100},
    {4'd15, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 3'b100}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0:                reqOf = "R1";
      4'd1:                reqOf = "R2";
      4'd2, 4'd3:          reqOf = "R3";
      4'd4, 4'd5, 4'd6, 4'd11: reqOf = "R4";
      4'd7:                reqOf = "R5";
      4'd8, 4'd9:          reqOf = "R6";
      4'd10:               reqOf = "R7";
      4'd12:               reqOf = "R8";
      default:             reqOf = "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf);
    opSel    = op;
    opA      = a;
    opB      = b;
    setFlags = sf;
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    finished = 1'b0;
    rstN     = 1'b0;
    drive(4'd0, 32'hFFFFFFFF, 32'h1, 1'b1);
    repeat (3) @(negedge clk);
    // R11: flags clear under reset
    check("R11 reset flags", {32'h0, flagZ, flagN, flagC}, 35'h0);
    rstN = 1'b1;

    // Table walk, R9 flag write with each entry
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][102:99], VEC[i][98:67], VEC[i][66:35], 1'b1);
      @(negedge clk);
      check($sformatf("%s/R9 vec%0d", reqOf(VEC[i][102:99]), i),
            {result, flagZ, flagN, flagC}, VEC[i][34:0]);
    end

    // R9: flags change only at the edge
    drive(4'd0, 32'hFFFFFFFF, 32'h1, 1'b1);
    @(negedge clk);
    check("R9 setup", {result, flagZ, flagN, flagC}, {32'h0, 3'b101});
    drive(4'd1, 32'h3, 32'h5, 1'b1);
    #2;
    check("R9 before edge", {result, flagZ, flagN, flagC}, {32'hFFFFFFFE, 3'b101});
    @(negedge clk);
    check("R9 after edge", {result, flagZ, flagN, flagC}, {32'hFFFFFFFE, 3'b011});

    // R10: hold with setFlags low across several edges and ops
    drive(4'd0, 32'h1, 32'h1, 1'b0);
    @(negedge clk);
    check("R10 hold add", {result, flagZ, flagN, flagC}, {32'h2, 3'b011});
    drive(4'd12, 32'h0, 32'h0, 1'b0);
    repeat (2) @(negedge clk);
    check("R10 hold clz", {result, flagZ, flagN, flagC}, {32'h20, 3'b011});

    // R4: invert ignores opB
    drive(4'd11, 32'h0F0F0000, 32'hFFFFFFFF, 1'b1);
    @(negedge clk);
    check("R4 invert opB ignored", {result, flagZ, flagN, flagC}, {32'hF0F0FFFF, 3'b010});

    // R5: shift amount wider than five bits uses low five bits only
    drive(4'd7, 32'h00000001, 32'hFFFFFFE4, 1'b1);
    @(negedge clk);
    check("R5 shl amount masked", {result, flagZ, flagN, flagC}, {32'h00000010, 3'b000});

    // R6: asr of positive value by 31
    drive(4'd9, 32'h40000000, 32'h0000001F, 1'b1);
    @(negedge clk);
    check("R6 asr positive", {result, flagZ, flagN, flagC}, {32'h0, 3'b101});

    // R11: reset mid-run clears flags
    drive(4'd1, 32'h0, 32'h1, 1'b1);
    @(negedge clk);
    check("R11 pre-reset", {result, flagZ, flagN, flagC}, {32'hFFFFFFFF, 3'b011});
    rstN = 1'b0;
    #2;
    check("R11 async clear", {32'h0, flagZ, flagN, flagC}, 35'h0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule